// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host end of a two-wire in-system programming link. A controller upstream hands it one operation at a time: load a word into the target's write latch, read a word back, step the target's address pointer, start a write cycle, or erase a whole memory. The sequencer turns each operation into a 6-bit command frame and, where the operation carries data, a 16-bit data frame. It drives the serial clock and data lines with bit timing set by parameters in system-clock cycles. It holds the clock quiet for the required gaps and for the write and erase times. It turns the data line around for read frames and returns the word the target sent.

The request side is valid/ready. `req_ready` is high only when the sequencer is idle. A request moves on the first rising clock edge where `req_valid` and `req_ready` are both high. The requester must keep `req_op` and `req_wdata` steady until that edge. Back-pressure lasts for the whole operation, including every gap and wait. The response side has no back-pressure. `rsp_valid` pulses for one cycle when the operation ends, and `rsp_data` holds its value until the next operation ends.

Top module: `isp_host_seq`

## Requirements
- R1: Whenever reset is asserted and afterwards until the first request, `isp_clk_o` is 0, `isp_dat_oe` is 1, `isp_dat_o` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: Every operation begins with a 6-bit command frame sent least significant bit first. Operation codes on `req_op` and the command codes they send: 0 load configuration = 0x00, 1 load program word = 0x02, 2 load data byte = 0x03, 3 read program word = 0x04, 4 read data byte = 0x05, 5 step address = 0x06, 6 program-memory write = 0x08, 7 data-memory write = 0x08, 8 erase program memory = 0x09, 9 erase data memory = 0x0B.
- R3: Each bit is a high clock phase of HALF_CYC cycles followed by a low phase of HALF_CYC cycles, so falling edges inside a frame are 2*HALF_CYC cycles apart. The data line changes only when the clock rises and is steady through each high phase.
- R4: A load frame has 16 bits: bit 0 is 0, bits 1 to 14 carry the 14-bit payload least significant bit first, and bit 15 is 0. For a data-byte load the payload is `req_wdata[7:0]` followed by six zero bits, whatever `req_wdata[13:8]` holds.
- R5: Between any two frames, and after the command of a step-address operation, the clock stays low for at least GAP_CYC cycles.
- R6: After a write command, `rsp_valid` comes at least PROG_CYC cycles after the last clock pulse for a program-memory write, and at least DPROG_CYC cycles after it for a data-memory write.
- R7: A program-memory erase sends a load-program-word command, a load frame with payload 0x3FFF and the erase command 0x09, in that order. It then waits at least ERASE_CYC cycles before `rsp_valid`.
- R8: A data-memory erase sends only the command 0x0B, with no data frame, and waits at least ERASE_CYC cycles before `rsp_valid`.
- R9: During the data frame of a read, `isp_dat_oe` is 0 for all 16 bits, and `isp_dat_i` is sampled as the clock falls. `rsp_data` is bits 1 to 14 of that frame. Operations that are not reads return `rsp_data` = 0.
- R10: `req_ready` is 0 from the cycle after acceptance until the operation ends, and `rsp_valid` is high for exactly one cycle.
- R11: Codes 10 to 15 on `req_op` are accepted and end with `rsp_valid` and `rsp_data` = 0, with no clock pulse on `isp_clk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_op | input | 4 | Operation code |
| req_wdata | input | 14 | Payload for load operations |
| rsp_valid | output | 1 | One-cycle pulse when an operation ends |
| rsp_data | output | 14 | Read payload, 0 for other operations |
| isp_clk_o | output | 1 | Serial programming clock |
| isp_dat_o | output | 1 | Serial data driven to the target |
| isp_dat_oe | output | 1 | Data line drive enable, 0 while the target drives |
| isp_dat_i | input | 1 | Serial data from the target |

## Verification
Falling edges inside a frame are due exactly 2*HALF_CYC cycles apart. The bench records the cycle of every falling edge and checks that spacing exactly. Gaps and waits are each a lower bound. For these the bench measures from the last falling edge to the next falling edge, or to `rsp_valid`. It accepts a delay of the parameter plus HALF_CYC, and for waits it allows a pipeline slack of up to six cycles. That slack keeps the program-memory, data-memory and erase waits apart. The target model and all samples act on the falling edge of the system clock. Read bits are therefore presented half a cycle after each serial rising edge and are stable well before the host samples them.

// File: rtl/isp_host_pkg.sv
package isp_host_pkg;

  localparam logic [3:0] OP_LOAD_CFG  = 4'd0;
  localparam logic [3:0] OP_LOAD_PGM  = 4'd1;
  localparam logic [3:0] OP_LOAD_DAT  = 4'd2;
  localparam logic [3:0] OP_READ_PGM  = 4'd3;
  localparam logic [3:0] OP_READ_DAT  = 4'd4;
  localparam logic [3:0] OP_STEP      = 4'd5;
  localparam logic [3:0] OP_WR_PGM    = 4'd6;
  localparam logic [3:0] OP_WR_DAT    = 4'd7;
  localparam logic [3:0] OP_ERASE_PGM = 4'd8;
  localparam logic [3:0] OP_ERASE_DAT = 4'd9;

  localparam logic [5:0] CMD_LOAD_CFG  = 6'h00;
  localparam logic [5:0] CMD_LOAD_PGM  = 6'h02;
  localparam logic [5:0] CMD_LOAD_DAT  = 6'h03;
  localparam logic [5:0] CMD_READ_PGM  = 6'h04;
  localparam logic [5:0] CMD_READ_DAT  = 6'h05;
  localparam logic [5:0] CMD_STEP      = 6'h06;
  localparam logic [5:0] CMD_WRITE     = 6'h08;
  localparam logic [5:0] CMD_ERASE_PGM = 6'h09;
  localparam logic [5:0] CMD_ERASE_DAT = 6'h0B;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_WAIT, ST_FIN} seq_st_e;
  typedef enum logic [1:0] {PH_PRE_CMD, PH_PRE_DAT, PH_CMD, PH_DAT} seq_ph_e;

  function automatic logic [5:0] op_cmd(input logic [3:0] op);
    case (op)
      OP_LOAD_CFG:  op_cmd = CMD_LOAD_CFG;
      OP_LOAD_PGM:  op_cmd = CMD_LOAD_PGM;
      OP_LOAD_DAT:  op_cmd = CMD_LOAD_DAT;
      OP_READ_PGM:  op_cmd = CMD_READ_PGM;
      OP_READ_DAT:  op_cmd = CMD_READ_DAT;
      OP_STEP:      op_cmd = CMD_STEP;
      OP_WR_PGM:    op_cmd = CMD_WRITE;
      OP_WR_DAT:    op_cmd = CMD_WRITE;
      OP_ERASE_PGM: op_cmd = CMD_ERASE_PGM;
      default:      op_cmd = CMD_ERASE_DAT;
    endcase
  endfunction

  function automatic logic op_known(input logic [3:0] op);
    op_known = (op <= OP_ERASE_DAT);
  endfunction

  function automatic logic op_is_read(input logic [3:0] op);
    op_is_read = (op == OP_READ_PGM) || (op == OP_READ_DAT);
  endfunction

  function automatic logic op_has_frame(input logic [3:0] op);
    op_has_frame = (op <= OP_READ_DAT);
  endfunction

endpackage

// File: rtl/isp_wait_timer.sv
module isp_wait_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] load,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt <= load;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) done <= 1'b1;
      end
    end
  end

  assign busy = (cnt != '0);

  // R5
  wait_done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/isp_frame_shifter.sv
module isp_frame_shifter #(
  parameter int HALF_CYC = 10,
  parameter int FRAME_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [4:0]         nbits,
  input  logic [FRAME_W-1:0] word,
  input  logic               drive,
  input  logic               sdi,
  output logic               busy,
  output logic               done,
  output logic [FRAME_W-3:0] cap,
  output logic               sclk,
  output logic               sdo,
  output logic               soe
);
  localparam int HW = (HALF_CYC < 2) ? 1 : $clog2(HALF_CYC);
  localparam logic [HW-1:0] HALF_LD = HW'(HALF_CYC - 1);
  localparam int BW = $clog2(FRAME_W);

  logic [HW-1:0]      hcnt;
  logic [BW-1:0]      bidx;
  logic [BW-1:0]      last;
  logic               hi;
  logic [FRAME_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cap   <= '0;
      sclk  <= 1'b0;
      sdo   <= 1'b0;
      soe   <= 1'b1;
      hcnt  <= '0;
      bidx  <= '0;
      last  <= '0;
      hi    <= 1'b0;
      shreg <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        shreg <= word;
        last  <= BW'(nbits - 5'd1);
        bidx  <= '0;
        hi    <= 1'b1;
        hcnt  <= HALF_LD;
        sclk  <= 1'b1;
        soe   <= drive;
        sdo   <= drive & word[0];
        cap   <= '0;
      end else if (busy) begin
        if (hcnt != '0) begin
          hcnt <= hcnt - 1'b1;
        end else if (hi) begin
          sclk <= 1'b0;
          hi   <= 1'b0;
          hcnt <= HALF_LD;
          if (bidx != '0 && bidx != BW'(FRAME_W - 1)) cap[bidx - 1'b1] <= sdi;
        end else if (bidx == last) begin
          busy <= 1'b0;
          done <= 1'b1;
          soe  <= 1'b1;
          sdo  <= 1'b0;
        end else begin
          bidx <= bidx + 1'b1;
          hi   <= 1'b1;
          sclk <= 1'b1;
          hcnt <= HALF_LD;
          sdo  <= soe & shreg[bidx + 1'b1];
        end
      end
    end
  end

  // R3
  data_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo));

  // R9
  release_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> soe);
endmodule

// File: rtl/isp_host_seq.sv
module isp_host_seq
  import isp_host_pkg::*;
#(
  parameter int HALF_CYC  = 10,
  parameter int GAP_CYC   = 100,
  parameter int PROG_CYC  = 400000,
  parameter int DPROG_CYC = 600000,
  parameter int ERASE_CYC = 600000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [3:0]  req_op,
  input  logic [13:0] req_wdata,
  output logic        rsp_valid,
  output logic [13:0] rsp_data,
  output logic        isp_clk_o,
  output logic        isp_dat_o,
  output logic        isp_dat_oe,
  input  logic        isp_dat_i
);
  localparam int MAX_A   = (PROG_CYC > DPROG_CYC) ? PROG_CYC : DPROG_CYC;
  localparam int MAX_B   = (ERASE_CYC > GAP_CYC) ? ERASE_CYC : GAP_CYC;
  localparam int MAX_W   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW      = $clog2(MAX_W + 1);
  localparam logic [15:0] ERASE_FRAME = {1'b0, 14'h3FFF, 1'b0};

  seq_st_e     st;
  seq_ph_e     ph;
  logic [3:0]  op_q;
  logic [13:0] pay_q;

  logic        sh_start, sh_drive, sh_busy, sh_done;
  logic [4:0]  sh_nbits;
  logic [15:0] sh_word;
  logic [13:0] sh_cap;

  logic          tm_start, tm_busy, tm_done;
  logic [CW-1:0] tm_load;
  logic [CW-1:0] op_wait;

  always_comb begin
    case (op_q)
      OP_WR_PGM:    op_wait = CW'(PROG_CYC);
      OP_WR_DAT:    op_wait = CW'(DPROG_CYC);
      OP_ERASE_PGM,
      OP_ERASE_DAT: op_wait = CW'(ERASE_CYC);
      default:      op_wait = CW'(GAP_CYC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ph        <= PH_CMD;
      op_q      <= '0;
      pay_q     <= '0;
      sh_start  <= 1'b0;
      sh_drive  <= 1'b1;
      sh_nbits  <= 5'd6;
      sh_word   <= '0;
      tm_start  <= 1'b0;
      tm_load   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      sh_start  <= 1'b0;
      tm_start  <= 1'b0;
      rsp_valid <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid) begin
          op_q  <= req_op;
          pay_q <= (req_op == OP_LOAD_DAT) ? {6'b0, req_wdata[7:0]} : req_wdata;
          if (!op_known(req_op)) begin
            st <= ST_FIN;
          end else begin
            st       <= ST_SHIFT;
            sh_start <= 1'b1;
            sh_drive <= 1'b1;
            sh_nbits <= 5'd6;
            if (req_op == OP_ERASE_PGM) begin
              ph      <= PH_PRE_CMD;
              sh_word <= {10'b0, CMD_LOAD_PGM};
            end else begin
              ph      <= PH_CMD;
              sh_word <= {10'b0, op_cmd(req_op)};
            end
          end
        end
        ST_SHIFT: if (sh_done) begin
          st       <= ST_WAIT;
          tm_start <= 1'b1;
          tm_load  <= (ph == PH_CMD && !op_has_frame(op_q)) ? op_wait : CW'(GAP_CYC);
        end
        ST_WAIT: if (tm_done) begin
          case (ph)
            PH_PRE_CMD: begin
              ph       <= PH_PRE_DAT;
              st       <= ST_SHIFT;
              sh_start <= 1'b1;
              sh_drive <= 1'b1;
              sh_nbits <= 5'd16;
              sh_word  <= ERASE_FRAME;
            end
            PH_PRE_DAT: begin
              ph       <= PH_CMD;
              st       <= ST_SHIFT;
              sh_start <= 1'b1;
              sh_drive <= 1'b1;
              sh_nbits <= 5'd6;
              sh_word  <= {10'b0, op_cmd(op_q)};
            end
            PH_CMD: begin
              if (op_has_frame(op_q)) begin
                ph       <= PH_DAT;
                st       <= ST_SHIFT;
                sh_start <= 1'b1;
                sh_drive <= !op_is_read(op_q);
                sh_nbits <= 5'd16;
                sh_word  <= {1'b0, pay_q, 1'b0};
              end else begin
                st <= ST_FIN;
              end
            end
            default: st <= ST_FIN;
          endcase
        end
        default: begin
          rsp_valid <= 1'b1;
          rsp_data  <= (op_known(op_q) && op_is_read(op_q)) ? sh_cap : 14'd0;
          st        <= ST_IDLE;
        end
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);

  isp_frame_shifter #(.HALF_CYC(HALF_CYC), .FRAME_W(16)) i_shifter (
    .clk   (clk),
    .rst_n (rst_n),
    .start (sh_start),
    .nbits (sh_nbits),
    .word  (sh_word),
    .drive (sh_drive),
    .sdi   (isp_dat_i),
    .busy  (sh_busy),
    .done  (sh_done),
    .cap   (sh_cap),
    .sclk  (isp_clk_o),
    .sdo   (isp_dat_o),
    .soe   (isp_dat_oe)
  );

  isp_wait_timer #(.CW(CW)) i_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tm_start),
    .load  (tm_load),
    .busy  (tm_busy),
    .done  (tm_done)
  );

  // R5
  quiet_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tm_busy |-> !isp_clk_o);

  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_busy || tm_busy) |-> !req_ready);

  // R10
  rsp_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11
  unknown_op_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !op_known(req_op)) |=> !sh_start);
endmodule

// File: tb/test_isp_host_seq.sv
module test_isp_host_seq;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 3;
  localparam int GAP   = 8;
  localparam int PROG  = 40;
  localparam int DPROG = 60;
  localparam int ERA   = 70;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_op = '0;
  logic [13:0] req_wdata = '0;
  logic isp_dat_i = 1'b0;
  logic req_ready, rsp_valid, isp_clk_o, isp_dat_o, isp_dat_oe;
  logic [13:0] rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  isp_host_seq #(.HALF_CYC(HALF), .GAP_CYC(GAP), .PROG_CYC(PROG),
                 .DPROG_CYC(DPROG), .ERASE_CYC(ERA)) i_isp_host_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .isp_clk_o(isp_clk_o), .isp_dat_o(isp_dat_o),
    .isp_dat_oe(isp_dat_oe), .isp_dat_i(isp_dat_i));

  int nvec = 0, nfail = 0, cyc = 0, lidx = 0, rcnt = 0, hold_viol = 0;
  bit wd = 1'b0;
  logic lbit [0:255];
  logic loe  [0:255];
  int   lt   [0:255];
  logic [15:0] rd_frame = '0;
  logic prev_clk = 1'b0, prev_dat = 1'b0, prev_oe = 1'b1;

  always @(posedge clk) cyc <= cyc + 1;

  // target model and line monitor, all on the system clock's falling edge
  always @(negedge clk) begin
    if (isp_clk_o && prev_clk && isp_dat_o != prev_dat) hold_viol = hold_viol + 1;
    if (!isp_clk_o && prev_clk) begin
      lbit[lidx % 256] = isp_dat_o;
      loe[lidx % 256]  = isp_dat_oe;
      lt[lidx % 256]   = cyc;
      lidx = lidx + 1;
    end
    if (!isp_dat_oe && prev_oe) rcnt = 0;
    if (isp_clk_o && !prev_clk && !isp_dat_oe) begin
      isp_dat_i = rd_frame[rcnt % 16];
      rcnt = rcnt + 1;
    end
    prev_clk = isp_clk_o;
    prev_dat = isp_dat_o;
    prev_oe  = isp_dat_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int fval(input int b, input int n);
    int v = 0;
    for (int i = 0; i < n; i++) v = v | (int'(lbit[(b + i) % 256]) << i);
    return v;
  endfunction

  function automatic bit spaced(input int b, input int n);
    bit ok = 1'b1;
    for (int i = 1; i < n; i++)
      if (lt[(b + i) % 256] - lt[(b + i - 1) % 256] != 2 * HALF) ok = 1'b0;
    return ok;
  endfunction

  task automatic run_op(input logic [3:0] op, input logic [13:0] wd_in,
                        output logic [13:0] rdata, output int tdone, output int base);
    @(negedge clk);
    base = lidx;
    req_valid = 1'b1;
    req_op = op;
    req_wdata = wd_in;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 ready low after accept", req_ready, 0);
    do @(negedge clk); while (!rsp_valid && !wd);
    tdone = cyc;
    rdata = rsp_data;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 rsp one cycle", rsp_valid, 0);
    chk(req_ready == 1'b1, "R10 ready back", req_ready, 1);
  endtask

  task automatic t_reset;
    chk(isp_clk_o == 0 && isp_dat_oe == 1 && isp_dat_o == 0, "R1 lines in reset",
        {isp_clk_o, isp_dat_oe, isp_dat_o}, 3'b010);
    chk(req_ready == 1 && rsp_valid == 0, "R1 handshake in reset", {req_ready, rsp_valid}, 2'b10);
  endtask

  task automatic t_load_pgm;
    logic [13:0] r; int td, b;
    run_op(4'd1, 14'h2A5C, r, td, b);
    chk(lidx - b == 22, "R4 load bit count", lidx - b, 22);
    chk(fval(b, 6) == 6'h02, "R2 load program cmd", fval(b, 6), 2);
    chk(fval(b + 6, 16) == {1'b0, 14'h2A5C, 1'b0}, "R4 load frame", fval(b + 6, 16), {1'b0, 14'h2A5C, 1'b0});
    chk(spaced(b, 6) && spaced(b + 6, 16), "R3 bit spacing", 0, 1);
    chk(lt[(b + 6) % 256] - lt[(b + 5) % 256] >= 2 * HALF + GAP, "R5 cmd-data gap",
        lt[(b + 6) % 256] - lt[(b + 5) % 256], 2 * HALF + GAP);
    chk(td - lt[(b + 21) % 256] >= HALF + GAP, "R5 gap after frame", td - lt[(b + 21) % 256], HALF + GAP);
    chk(r == 14'd0, "R9 non-read rsp zero", r, 0);
  endtask

  task automatic t_load_dat;
    logic [13:0] r; int td, b;
    run_op(4'd2, 14'h3F81, r, td, b);
    chk(fval(b, 6) == 6'h03, "R2 load data cmd", fval(b, 6), 3);
    chk(fval(b + 6, 16) == 16'h0102, "R4 byte payload zero padded", fval(b + 6, 16), 16'h0102);
  endtask

  task automatic t_load_cfg;
    logic [13:0] r; int td, b;
    run_op(4'd0, 14'h1234, r, td, b);
    chk(fval(b, 6) == 6'h00 && lidx - b == 22, "R2 load config cmd", fval(b, 6), 0);
    chk(fval(b + 6, 16) == {1'b0, 14'h1234, 1'b0}, "R4 config frame", fval(b + 6, 16), {1'b0, 14'h1234, 1'b0});
  endtask

  task automatic t_step;
    logic [13:0] r; int td, b;
    run_op(4'd5, 14'h3FFF, r, td, b);
    chk(lidx - b == 6 && fval(b, 6) == 6'h06, "R2 step cmd only", fval(b, 6), 6);
    chk(td - lt[(b + 5) % 256] >= HALF + GAP, "R5 gap after step", td - lt[(b + 5) % 256], HALF + GAP);
  endtask

  task automatic t_read(input logic [3:0] op, input logic [5:0] cmd, input logic [13:0] val);
    logic [13:0] r; int td, b, drv;
    rd_frame = {1'b0, val, 1'b0};
    run_op(op, 14'h0, r, td, b);
    chk(fval(b, 6) == cmd, "R2 read cmd", fval(b, 6), cmd);
    drv = 0;
    for (int i = 6; i < 22; i++) drv += int'(loe[(b + i) % 256]);
    chk(lidx - b == 22 && drv == 0, "R9 line released in read frame", drv, 0);
    chk(r == val, "R9 read data", r, val);
  endtask

  task automatic t_wait(input logic [3:0] op, input logic [5:0] cmd, input int w, input string tag);
    logic [13:0] r; int td, b, d;
    run_op(op, 14'h0, r, td, b);
    chk(lidx - b == 6 && fval(b, 6) == cmd, {tag, " cmd"}, fval(b, 6), cmd);
    d = td - lt[(b + 5) % 256];
    chk(d >= HALF + w && d <= HALF + w + 6, {tag, " wait"}, d, HALF + w);
  endtask

  task automatic t_erase_pgm;
    logic [13:0] r; int td, b, d;
    run_op(4'd8, 14'h0, r, td, b);
    chk(lidx - b == 28, "R7 erase preamble bit count", lidx - b, 28);
    chk(fval(b, 6) == 6'h02 && fval(b + 6, 16) == 16'h7FFE, "R7 preamble load 0x3FFF",
        fval(b + 6, 16), 16'h7FFE);
    chk(fval(b + 22, 6) == 6'h09, "R7 erase cmd", fval(b + 22, 6), 9);
    d = td - lt[(b + 27) % 256];
    chk(d >= HALF + ERA && d <= HALF + ERA + 6, "R7 erase wait", d, HALF + ERA);
  endtask

  task automatic t_unknown;
    logic [13:0] r; int td, b;
    run_op(4'd12, 14'h3FFF, r, td, b);
    chk(lidx == b && r == 14'd0, "R11 unknown op quiet", lidx - b, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_pgm();
    t_load_dat();
    t_load_cfg();
    t_step();
    t_read(4'd3, 6'h04, 14'h1ABC);
    t_read(4'd4, 6'h05, 14'h00C3);
    t_wait(4'd6, 6'h08, PROG, "R6 program write");
    t_wait(4'd7, 6'h08, DPROG, "R6 data write");
    t_erase_pgm();
    t_wait(4'd9, 6'h0B, ERA, "R8 data erase");
    t_unknown();
    chk(hold_viol == 0, "R3 data steady while clock high", hold_viol, 0);
    if (!wd) begin
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    wd = 1'b1;
    nvec++;
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule